// File: doc/BRIEF.md
# Byte-Access Control Register Target for a Two-Wire Management Bus

This block is a target on an SMBus/I2C-style two-wire bus that gives a host byte-wide access to a small bank of clock-generator control registers. It samples SCL and SDA through synchronizers running on a faster system clock. It detects START, repeated START and STOP, matches its 7-bit target address and acknowledges the bytes it accepts. It only ever pulls SDA low, and the pad logic outside the block forms the wired-AND line.

A transfer carries a command byte. When bit 7 of that byte is set, the transfer is a byte access and bits 6:0 select the register. A write then delivers one data byte to that register. A read uses a repeated START with the direction bit set, and the target shifts the register out MSB first. The host ends the read with a NACK and a STOP.

The bank has two registers. Register 0 holds a drive-strength select and five strap bits that are captured once after reset. Register 1 holds three output enables for differential clock pairs. All other bits are fixed reserved values. The drive-strength select and the output enables also leave the block as parallel outputs.

Top module: `smb_reg_target`

## Requirements
- R1: After reset, `drive_hi_o` is 1, `out_en_o` is 3'b111 and `sda_oe_o` is 0.
- R2: `strap_i` is captured on the first clock after `rst_ni` is released and is never captured again. Register 0 bits 4:0 read back the captured value.
- R3: The target pulls SDA low in the acknowledge slot only when the 7 address bits match `TGT_ADDR`. On a mismatch it never drives SDA and changes no register until the next START.
- R4: A byte write to offset 0 with command 0x80 sets `drive_hi_o` to data bit 6.
- R5: A byte write to offset 1 with command 0x81 sets `out_en_o` to data bits 2:0. `out_en_o` changes only after such a write.
- R6: A read (write of address and command, repeated START, address with direction bit 1) returns the addressed register MSB first. Register 0 reads as {0, drive_hi, 0, strap[4:0]} and register 1 reads as {0, 1111, out_en[2:0]}.
- R7: Writes to reserved bits and strap bits have no effect. Register 0 bits 7 and 5 read 0, register 1 bit 7 reads 0 and bits 6:3 read 1.
- R8: A write to any offset above 1 changes nothing, and a read of such an offset returns 0x00. Both are still acknowledged.
- R9: A command byte with bit 7 clear is acknowledged but gives no register access. The data byte written after it changes no output, and a read returns 0x00.
- R10: SDA drive changes only while SCL is low. After the host NACKs the read byte, the target releases SDA, and after the STOP a new transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 5 | Frequency-select strap pins |
| drive_hi_o | output | 1 | 1 selects high drive strength |
| out_en_o | output | 3 | Output enables for the clock pairs; 0 places a pair in high impedance |

## Verification
The hardest situation to reach is the read turnaround. There the target must take a repeated START in the middle of a transfer, return the line to the host, drive a byte whose bits switch between pulling low and releasing, and then see the host NACK. The bench models the line as the wired-AND of the host's drive and the target's `sda_oe_o`. It moves the host's SDA only a quarter bit away from each SCL edge, so START and STOP appear only on purpose. It runs write and read pairs that make the target drive both 0 and 1 bits, and it checks that SDA is released in the NACK slot and again after the STOP.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned OFF_W   = BYTE_W - 1;
  localparam int unsigned STRAP_W = 5;
  localparam int unsigned OE_W    = 3;
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_CMD, ST_ACK_CMD,
    ST_DATA, ST_ACK_DATA, ST_TX, ST_ACK_RX, ST_IGNORE
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;  // idle bus is high
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign q_o    = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/smb_bus_fsm.sv
`timescale 1ns/1ps
module smb_bus_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h69
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_q_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_q_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] cmd_o,
  output smb_state_e        state_o
);
  smb_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, cmd_q;
  logic              rw_q, host_ack_q, oe_q, wr_q;

  wire start_det = scl_q_i & sda_fall_i;
  wire stop_det  = scl_q_i & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0; cmd_q <= '0;
      rw_q <= 1'b0; host_ack_q <= 1'b0; oe_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR; cnt_q <= '0; oe_q <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE; oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (scl_rise_i && cnt_q != CNT_W'(BYTE_W)) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_q_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[BYTE_W-1:1] == TGT_ADDR) begin
                  oe_q <= 1'b1; rw_q <= sh_q[0]; state_q <= ST_ACK_ADDR;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (state_q == ST_CMD) begin
                oe_q <= 1'b1; cmd_q <= sh_q; state_q <= ST_ACK_CMD;
              end else begin
                oe_q <= 1'b1; wr_q <= cmd_q[BYTE_W-1]; state_q <= ST_ACK_DATA;
              end
            end
          end
          ST_ACK_ADDR: if (scl_fall_i) begin
            if (rw_q) begin
              tx_q <= rd_data_i; oe_q <= ~rd_data_i[BYTE_W-1]; state_q <= ST_TX;
            end else begin
              oe_q <= 1'b0; state_q <= ST_CMD;
            end
          end
          ST_ACK_CMD: if (scl_fall_i) begin
            oe_q <= 1'b0; state_q <= ST_DATA;
          end
          ST_ACK_DATA: if (scl_fall_i) begin
            oe_q <= 1'b0; state_q <= ST_IGNORE;
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              oe_q <= 1'b0; cnt_q <= '0; state_q <= ST_ACK_RX;
            end else begin
              oe_q  <= ~tx_q[BYTE_W-2];
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ACK_RX: begin
            if (scl_rise_i) host_ack_q <= ~sda_q_i;
            else if (scl_fall_i) begin
              if (host_ack_q) begin
                tx_q <= rd_data_i; oe_q <= ~rd_data_i[BYTE_W-1]; state_q <= ST_TX;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_q;
  assign wr_data_o = sh_q;
  assign cmd_o     = cmd_q;
  assign state_o   = state_q;
endmodule

// File: rtl/smb_reg_bank.sv
`timescale 1ns/1ps
module smb_reg_bank
  import smb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_en_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  output logic [BYTE_W-1:0]  rd_data_o,
  output logic               drive_hi_o,
  output logic [OE_W-1:0]    out_en_o,
  output logic [STRAP_W-1:0] strap_val_o,
  output logic               strap_done_o
);
  localparam int unsigned DRV_BIT = 6;
  localparam int unsigned R1_FIX  = BYTE_W - 1 - OE_W;

  logic [STRAP_W-1:0] strap_q;
  logic               done_q, drv_q;
  logic [OE_W-1:0]    oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0; done_q <= 1'b0; drv_q <= 1'b1; oe_q <= '1;
    end else begin
      if (!done_q) begin
        strap_q <= strap_i; done_q <= 1'b1;
      end
      if (wr_en_i && off_i == OFF_W'(0)) drv_q <= wr_data_i[DRV_BIT];
      if (wr_en_i && off_i == OFF_W'(1)) oe_q  <= wr_data_i[OE_W-1:0];
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_W'(0): rd_data_o = {1'b0, drv_q, 1'b0, strap_q};
      OFF_W'(1): rd_data_o = {1'b0, {R1_FIX{1'b1}}, oe_q};
      default:   rd_data_o = '0;
    endcase
  end

  assign drive_hi_o   = drv_q;
  assign out_en_o     = oe_q;
  assign strap_val_o  = strap_q;
  assign strap_done_o = done_q;
endmodule

// File: rtl/smb_reg_target.sv
`timescale 1ns/1ps
module smb_reg_target
  import smb_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               drive_hi_o,
  output logic [OE_W-1:0]    out_en_o
);
  logic [1:0] line_d, line_q, line_rise, line_fall;
  assign line_d = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (line_d[g]),
      .q_o (line_q[g]), .rise_o (line_rise[g]), .fall_o (line_fall[g])
    );
  end

  logic [BYTE_W-1:0]  bank_rd, rd_data, wr_data, cmd;
  logic               wr_en, strap_done;
  logic [STRAP_W-1:0] strap_val;
  smb_state_e         state;

  // command bit 7 clear gives no register access
  assign rd_data = cmd[BYTE_W-1] ? bank_rd : '0;

  smb_bus_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .scl_q_i (line_q[0]), .scl_rise_i (line_rise[0]), .scl_fall_i (line_fall[0]),
    .sda_q_i (line_q[1]), .sda_rise_i (line_rise[1]), .sda_fall_i (line_fall[1]),
    .rd_data_i (rd_data), .sda_oe_o (sda_oe_o), .wr_en_o (wr_en),
    .wr_data_o (wr_data), .cmd_o (cmd), .state_o (state)
  );

  smb_reg_bank u_bank (
    .clk_i (clk_i), .rst_ni (rst_ni), .strap_i (strap_i),
    .wr_en_i (wr_en), .off_i (cmd[OFF_W-1:0]), .wr_data_i (wr_data),
    .rd_data_o (bank_rd), .drive_hi_o (drive_hi_o), .out_en_o (out_en_o),
    .strap_val_o (strap_val), .strap_done_o (strap_done)
  );
endmodule

// File: rtl/smb_reg_target_chk.sv
`timescale 1ns/1ps
module smb_reg_target_chk
  import smb_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic               drive_hi_o,
  input logic [OE_W-1:0]    out_en_o,
  input logic               wr_en,
  input logic               strap_done,
  input logic [STRAP_W-1:0] strap_val,
  input smb_state_e         state
);
  // R2
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_done && $past(strap_done)) |-> $stable(strap_val));

  // R3
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe_o);

  // R4
  drive_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drive_hi_o) |-> $past(wr_en));

  // R5
  oe_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_en_o) |-> $past(wr_en));

  // R10
  sda_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind smb_reg_target smb_reg_target_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .scl_i (scl_i), .sda_oe_o (sda_oe_o),
  .drive_hi_o (drive_hi_o), .out_en_o (out_en_o), .wr_en (wr_en),
  .strap_done (strap_done), .strap_val (strap_val), .state (state)
);

// File: tb/smb_reg_target_bench.sv
`timescale 1ns/1ps
module smb_reg_target_bench;
  localparam logic [6:0] TGT = 7'h69;

  logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_sda = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic       sda_oe, drive_hi;
  logic [2:0] out_en;
  wire        sda_line = host_sda & ~sda_oe;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  smb_reg_target u_smb_reg_target (
    .clk_i (clk), .rst_ni (rst_n), .scl_i (scl), .sda_i (sda_line),
    .sda_oe_o (sda_oe), .strap_i (strap), .drive_hi_o (drive_hi), .out_en_o (out_en)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (10) @(negedge clk); endtask

  task automatic bus_start();
    host_sda = 1'b1; q(); scl = 1'b1; q(); host_sda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; q(); scl = 1'b1; q(); host_sda = 1'b1; q();
  endtask

  task automatic put_bit(input logic b);
    host_sda = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; q(); scl = 1'b1; q(); b = sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                          output logic [2:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] cmd, output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({TGT, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    bus_start();
    send_byte({TGT, 1'b1}, acks[0]);
    recv_byte(d);
    put_bit(1'b1);  // host NACK
    check(sda_oe == 1'b0, "R10 released after NACK", {7'd0, sda_oe}, 8'h00);
    bus_stop();
    q();
    check(sda_oe == 1'b0, "R10 released after STOP", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_reset();
    check(drive_hi == 1'b1, "R1 drive_hi", {7'd0, drive_hi}, 8'h01);
    check(out_en == 3'b111, "R1 out_en", {5'd0, out_en}, 8'h07);
    check(sda_oe == 1'b0, "R1 sda_oe", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_strap();
    logic [7:0] d; logic [2:0] a;
    strap = 5'b01001;  // after capture: must not be seen
    do_read(8'h80, d, a);
    check(a == 3'b111, "R6 read acks", {5'd0, a}, 8'h07);
    check(d == 8'h56, "R2 strap captured once / R6 reg0", d, 8'h56);
  endtask

  task automatic t_drive();
    logic [7:0] d; logic [2:0] a;
    do_write(TGT, 8'h80, 8'h00, a);
    check(a == 3'b111, "R4 write acks", {5'd0, a}, 8'h07);
    check(drive_hi == 1'b0, "R4 drive low", {7'd0, drive_hi}, 8'h00);
    do_read(8'h80, d, a);
    check(d == 8'h16, "R6 reg0 after clear", d, 8'h16);
    do_write(TGT, 8'h80, 8'hFF, a);
    check(drive_hi == 1'b1, "R4 drive high", {7'd0, drive_hi}, 8'h01);
    do_read(8'h80, d, a);
    check(d == 8'h56, "R7 reg0 reserved/strap unwritable", d, 8'h56);
  endtask

  task automatic t_oe();
    logic [7:0] d; logic [2:0] a;
    do_write(TGT, 8'h81, 8'h05, a);
    check(out_en == 3'b101, "R5 out_en 101", {5'd0, out_en}, 8'h05);
    do_read(8'h81, d, a);
    check(d == 8'h7D, "R6 reg1 read", d, 8'h7D);
    do_write(TGT, 8'h81, 8'h80, a);
    check(out_en == 3'b000, "R5 out_en 000", {5'd0, out_en}, 8'h00);
    do_read(8'h81, d, a);
    check(d == 8'h78, "R7 reg1 reserved fixed", d, 8'h78);
  endtask

  task automatic t_bad_addr();
    logic [2:0] a;
    do_write(7'h12, 8'h81, 8'hFF, a);
    check(a[2] == 1'b0, "R3 no ack on mismatch", {7'd0, a[2]}, 8'h00);
    check(out_en == 3'b000, "R3 no write on mismatch", {5'd0, out_en}, 8'h00);
  endtask

  task automatic t_high_off();
    logic [7:0] d; logic [2:0] a;
    do_write(TGT, 8'h85, 8'hFF, a);
    check(a == 3'b111, "R8 acks high offset", {5'd0, a}, 8'h07);
    check(out_en == 3'b000 && drive_hi, "R8 no effect", {4'd0, drive_hi, out_en}, 8'h08);
    do_read(8'h85, d, a);
    check(d == 8'h00, "R8 read high offset", d, 8'h00);
  endtask

  task automatic t_no_byte_cmd();
    logic [7:0] d; logic [2:0] a;
    do_write(TGT, 8'h01, 8'hFF, a);
    check(a == 3'b111, "R9 acks non-byte cmd", {5'd0, a}, 8'h07);
    check(out_en == 3'b000, "R9 no write", {5'd0, out_en}, 8'h00);
    do_read(8'h00, d, a);
    check(d == 8'h00, "R9 read returns 0", d, 8'h00);
    do_read(8'h81, d, a);
    check(d == 8'h78 && a == 3'b111, "R10 new transfer after STOP", d, 8'h78);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_strap();
    t_drive();
    t_oe();
    t_bad_addr();
    t_high_off();
    t_no_byte_cmd();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x00 expected=0x01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule